// File: doc/BRIEF.md
# Dual-Mode Host Register Interface

This block lets a small microcontroller reach a bank of eight 8-bit registers over one of two port styles. In parallel mode the host drives a register index onto a shared address/data bus, strobes the address latch enable, and then reads or writes a whole byte using active-low read and write strobes. In serial mode the same pins are reused: the low three bus bits hold the register index steadily, and bus bit 7 becomes a single bidirectional data line. Bits move one at a time, least significant first, and an external serial clock paces them.

All pins are sampled by the block's own system clock. Edges on the strobes and on the serial clock are found by comparing each sample with the previous one, so every external phase must last at least two system clock cycles. Register 2 holds no storage. A read of it returns the live status inputs, captured when the read begins, and writes to it are dropped. The other seven registers appear on a flat output vector for the logic they control.

Top module: `hri_host_if`

## Requirements
- R1: After reset every writable register holds 0x00, the register 2 slot of `regs_o` reads 0x00, and `ad_oe` is all zero.
- R2: In parallel mode, the low three bus bits and `cs_n` are captured when `ale` falls. The byte on `ad_i` is written to the captured register when `wr_n` rises, provided the captured `cs_n` was low. Registers change on no other event.
- R3: A parallel access whose captured `cs_n` is high does nothing. Its write changes no register, and its read leaves `ad_oe` at zero.
- R4: A parallel read with captured `cs_n` low sets all eight `ad_oe` bits while `rd_n` is low. From the second clock edge after `rd_n` falls, `ad_o` carries the selected register.
- R5: Serial mode is active whenever `ale` is high and `cs_n` is low. In that mode `ad_i[7]` / `ad_o[7]` is the data line, and `ad_i[2:0]` gives the register index, held stable for the whole transfer.
- R6: A serial write takes one data bit on each falling edge of `sclk` while `rd_n` is high, least significant bit first. Once eight bits have been taken, a rising edge of `wr_n` stores the byte in the register at `ad_i[2:0]`.
- R7: A serial read captures the register when `rd_n` falls and presents bit 0 on `ad_o[7]`. Each falling `sclk` edge while `rd_n` stays low moves on to the next bit. Only `ad_oe[7]` is set in serial mode, and only while `rd_n` is low.
- R8: Register 2 ignores writes from both ports. Reads of it return `status_i` as sampled at the falling edge of `rd_n`, and later changes during the same read have no effect.
- R9: The serial bit counter clears when `rd_n` or `wr_n` rises. A serial write strobe that follows fewer than eight bits leaves every register unchanged, and the next full transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable; held high with `cs_n` low to select serial mode |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| sclk | input | 1 | External serial shift clock, used on its falling edge |
| ad_i | input | 8 | Bus value seen at the pins |
| ad_o | output | 8 | Bus value the block drives |
| ad_oe | output | 8 | Per-bit output enable for `ad_o` |
| status_i | input | 8 | Live read-only status returned by register 2 |
| regs_o | output | 64 | Contents of all eight registers, register n at bits 8n+7:8n |

## Verification
The state that can go wrong is the latched index and select, the serial bit counter, and the read holding register. A bad latched index sends a parallel write to the wrong byte of `regs_o` one clock after `wr_n` rises. A counter that does not clear or does not saturate either drops a valid serial write or accepts a short one, which shows on `regs_o` right after the strobe. A holding register that shifts in the wrong direction or loads at the wrong moment puts the wrong bit on `ad_o[7]` at the very first sample after `rd_n` falls, or after the first `sclk` fall.

// File: rtl/hri_pkg.sv
package hri_pkg;
   typedef enum logic {
      MODE_PAR = 1'b0,
      MODE_SER = 1'b1
   } hri_mode_e;

   // serial access is requested by holding the latch enable high with the chip selected
   function automatic hri_mode_e hri_mode(input logic ale, input logic cs_n);
      return (ale && !cs_n) ? MODE_SER : MODE_PAR;
   endfunction
endpackage

// File: rtl/hri_edge.sv
module hri_edge #(
   parameter int N = 4,
   parameter logic [N-1:0] IDLE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE;
      else        prev <= sig;
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      assign rise[g] = !prev[g] &&  sig[g];
      assign fall[g] =  prev[g] && !sig[g];
   end
endmodule

// File: rtl/hri_regbank.sv
module hri_regbank #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int RO_IDX = 2,
   localparam int NREG  = 1 << ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      waddr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic [ADDR_W-1:0]      raddr,
   input  logic [DATA_W-1:0]      status_i,
   output logic [DATA_W-1:0]      rdata,
   output logic [NREG*DATA_W-1:0] regs_o
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == RO_IDX) begin : g_ro
         assign regs_o[g*DATA_W +: DATA_W] = '0;
      end else begin : g_rw
         logic [DATA_W-1:0] store;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         store <= '0;
            else if (we && waddr == ADDR_W'(g)) store <= wdata;
         end
         assign regs_o[g*DATA_W +: DATA_W] = store;
      end
   end

   always_comb begin
      if (raddr == ADDR_W'(RO_IDX)) rdata = status_i;
      else                          rdata = regs_o[int'(raddr)*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/hri_shift.sv
module hri_shift #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_mode,
   input  logic              rd_n,
   input  logic              sclk_fall,
   input  logic              rd_fall,
   input  logic              strobe_rise,
   input  logic              din,
   input  logic [DATA_W-1:0] load_val,
   output logic              in_full,
   output logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] hold
);
   logic [CNT_W-1:0] cnt;

   // read side: captured at the start of the read, then moved right one bit per clock fall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 hold <= '0;
      else if (rd_fall)                           hold <= load_val;
      else if (ser_mode && !rd_n && sclk_fall)    hold <= hold >> 1;
   end

   // write side: bits enter at the top so the first one ends at bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_data <= '0;
         cnt     <= '0;
      end else if (strobe_rise) begin
         cnt <= '0;
      end else if (ser_mode && rd_n && sclk_fall) begin
         in_data <= {din, in_data[DATA_W-1:1]};
         if (cnt != CNT_W'(DATA_W)) cnt <= cnt + 1'b1;
      end
   end

   assign in_full = (cnt == CNT_W'(DATA_W));
endmodule

// File: rtl/hri_host_if.sv
module hri_host_if #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int RO_IDX = 2,
   localparam int NREG    = 1 << ADDR_W,
   localparam int SER_BIT = DATA_W - 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ale,
   input  logic                   cs_n,
   input  logic                   rd_n,
   input  logic                   wr_n,
   input  logic                   sclk,
   input  logic [DATA_W-1:0]      ad_i,
   output logic [DATA_W-1:0]      ad_o,
   output logic [DATA_W-1:0]      ad_oe,
   input  logic [DATA_W-1:0]      status_i,
   output logic [NREG*DATA_W-1:0] regs_o
);
   import hri_pkg::*;

   if (ADDR_W >= DATA_W) begin : g_bad_addr
      $error("register index bits overlap the serial data bit");
   end
   if (RO_IDX >= NREG) begin : g_bad_ro
      $error("read-only slot lies outside the bank");
   end

   // pin index order in the edge detector: ale, rd_n, wr_n, sclk
   logic [3:0] rise, fall;
   hri_edge #(.N(4), .IDLE(4'b0110)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig({sclk, wr_n, rd_n, ale}),
      .rise(rise), .fall(fall)
   );
   wire ale_fall  = fall[0];
   wire rd_fall   = fall[1];
   wire rd_rise   = rise[1];
   wire wr_rise   = rise[2];
   wire sclk_fall = fall[3];

   hri_mode_e mode;
   assign mode = hri_mode(ale, cs_n);

   logic [ADDR_W-1:0] addr_l;
   logic              cs_l;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_l <= '0;
         cs_l   <= 1'b1;
      end else if (ale_fall) begin
         addr_l <= ad_i[ADDR_W-1:0];
         cs_l   <= cs_n;
      end
   end

   logic [ADDR_W-1:0] sel;
   assign sel = (mode == MODE_SER) ? ad_i[ADDR_W-1:0] : addr_l;

   logic              in_full;
   logic [DATA_W-1:0] in_data, hold, rdata;
   hri_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .ser_mode(mode == MODE_SER), .rd_n(rd_n),
      .sclk_fall(sclk_fall), .rd_fall(rd_fall), .strobe_rise(rd_rise || wr_rise),
      .din(ad_i[SER_BIT]), .load_val(rdata),
      .in_full(in_full), .in_data(in_data), .hold(hold)
   );

   logic              we;
   logic [DATA_W-1:0] wdata;
   always_comb begin
      if (mode == MODE_SER) begin
         we    = wr_rise && in_full;
         wdata = in_data;
      end else begin
         we    = wr_rise && !cs_l;
         wdata = ad_i;
      end
   end

   hri_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RO_IDX(RO_IDX)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(sel), .wdata(wdata),
      .raddr(sel), .status_i(status_i), .rdata(rdata), .regs_o(regs_o)
   );

   always_comb begin
      ad_o  = '0;
      ad_oe = '0;
      if (mode == MODE_SER) begin
         if (!rd_n) begin
            ad_o[SER_BIT]  = hold[0];
            ad_oe[SER_BIT] = 1'b1;
         end
      end else if (!rd_n && !cs_l) begin
         ad_o  = hold;
         ad_oe = '1;
      end
   end
endmodule

// File: rtl/hri_host_if_chk.sv
module hri_host_if_chk #(
   parameter int DATA_W = 8,
   parameter int NREG   = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ale,
   input logic                   cs_n,
   input logic                   rd_n,
   input logic                   wr_n,
   input logic [DATA_W-1:0]      ad_oe,
   input logic [NREG*DATA_W-1:0] regs_o
);
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs_o == '0));

   assert_write_only_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_n && !$past(wr_n)) |=> $stable(regs_o));

   assert_parallel_full_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ale && !cs_n) && ad_oe != '0) |-> (ad_oe == '1));

   assert_serial_single_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && !cs_n) |-> (ad_oe[DATA_W-2:0] == '0));

   assert_drive_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> (ad_oe == '0));
endmodule

bind hri_host_if hri_host_if_chk #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
   .ad_oe(ad_oe), .regs_o(regs_o)
);

// File: tb/hri_host_if_bench.sv
`timescale 1ns/1ps
module hri_host_if_bench;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sclk = 1'b0;
   logic [7:0]  ad_i = '0, status_i = '0;
   logic [7:0]  ad_o, ad_oe;
   logic [63:0] regs_o;

   hri_host_if u_hri_host_if (
      .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .sclk(sclk), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .status_i(status_i), .regs_o(regs_o)
   );

   always #2.5 clk = ~clk;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [7:0] model [8];
   logic [7:0] exp_q [$];
   string      req_q [$];
   logic [7:0] obs_q [$];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // monitor: matches each observed read byte with the expected one pushed by the driver
   initial forever begin
      wait (obs_q.size() != 0);
      chk(req_q.pop_front(), {56'h0, obs_q.pop_front()}, {56'h0, exp_q.pop_front()});
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      wrap_up();
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [63:0] flat();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[i*8 +: 8] = (i == 2) ? 8'h00 : model[i];
      return v;
   endfunction

   task automatic latch(input logic [2:0] a, input logic cs);
      ale = 1'b1; cs_n = cs; ad_i = {5'b0, a};
      idle(2);
      ale = 1'b0;
      idle(2);
   endtask

   task automatic par_write(input logic [2:0] a, input logic [7:0] d, input logic cs, input string req);
      latch(a, cs);
      ad_i = d; wr_n = 1'b0;
      idle(2);
      wr_n = 1'b1;
      idle(2);
      cs_n = 1'b1;
      if (!cs && a != 3'd2) model[a] = d;
      chk(req, regs_o, flat());
   endtask

   task automatic par_read(input logic [2:0] a, input logic [7:0] exp, input string req);
      latch(a, 1'b0);
      rd_n = 1'b0;
      exp_q.push_back(exp); req_q.push_back(req);
      idle(3);
      chk({req, " oe"}, {56'h0, ad_oe}, 64'hFF);
      obs_q.push_back(ad_o);
      rd_n = 1'b1;
      idle(2);
      cs_n = 1'b1;
   endtask

   task automatic ser_enter();
      ale = 1'b1; cs_n = 1'b0;
      idle(2);
   endtask

   task automatic ser_write(input logic [2:0] a, input logic [7:0] d, input int nbits, input string req);
      ad_i = {5'b0, a};
      for (int i = 0; i < nbits; i++) begin
         ad_i[7] = d[i]; sclk = 1'b1;
         idle(2);
         sclk = 1'b0;
         idle(2);
      end
      wr_n = 1'b0;
      idle(2);
      wr_n = 1'b1;
      idle(2);
      if (nbits >= 8 && a != 3'd2) model[a] = d;
      chk(req, regs_o, flat());
   endtask

   task automatic ser_read(input logic [2:0] a, input logic [7:0] exp, input logic [7:0] st_mid, input string req);
      logic [7:0] got;
      ad_i = {5'b0, a};
      rd_n = 1'b0;
      exp_q.push_back(exp); req_q.push_back(req);
      idle(3);
      chk({req, " oe"}, {56'h0, ad_oe}, 64'h80);
      for (int i = 0; i < 8; i++) begin
         got[i] = ad_o[7];
         if (i == 0) status_i = st_mid;
         sclk = 1'b1;
         idle(2);
         sclk = 1'b0;
         idle(3);
      end
      obs_q.push_back(got);
      rd_n = 1'b1;
      idle(2);
      chk("R7 no drive after read", {56'h0, ad_oe}, 64'h0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk("R1 regs after reset", regs_o, 64'h0);
      chk("R1 oe after reset", {56'h0, ad_oe}, 64'h0);

      par_write(3'd1, 8'hA5, 1'b0, "R2 write r1");
      par_write(3'd5, 8'h3C, 1'b0, "R2 write r5");
      par_write(3'd7, 8'hFF, 1'b0, "R2 write r7");
      par_read(3'd1, 8'hA5, "R4 read r1");
      par_read(3'd5, 8'h3C, "R4 read r5");
      par_read(3'd7, 8'hFF, "R4 read r7");

      par_write(3'd3, 8'h77, 1'b1, "R3 deselected write");
      par_read(3'd3, 8'h00, "R3 r3 untouched");
      latch(3'd1, 1'b1);
      rd_n = 1'b0;
      idle(3);
      chk("R3 deselected read oe", {56'h0, ad_oe}, 64'h0);
      rd_n = 1'b1;
      idle(2);

      par_write(3'd2, 8'hEE, 1'b0, "R8 parallel write r2");
      status_i = 8'h5A;
      par_read(3'd2, 8'h5A, "R8 parallel status read");

      ser_enter();
      chk("R5 serial idle no drive", {56'h0, ad_oe}, 64'h0);
      ser_write(3'd4, 8'h96, 8, "R6 serial write r4");
      ser_read(3'd4, 8'h96, status_i, "R5 serial read back r4");
      ser_read(3'd1, 8'hA5, status_i, "R7 serial read r1");
      status_i = 8'hC1;
      ser_read(3'd2, 8'hC1, 8'h0F, "R8 status held during read");
      ser_write(3'd2, 8'h44, 8, "R8 serial write r2");
      ser_write(3'd6, 8'h11, 5, "R9 short write r6");
      ser_write(3'd6, 8'hC3, 8, "R9 full write after short");
      par_read(3'd6, 8'hC3, "R6 parallel view of serial write");
      par_read(3'd4, 8'h96, "R5 parallel view r4");

      wait (obs_q.size() == 0);
      idle(2);
      wrap_up();
   end
endmodule